// File: doc/BRIEF.md
# Rational clock token generator

This block produces an unending stream of clock tokens for a fixed set of target clocks. Each clock's period is a rational multiple of a common base, given as a numerator and a denominator per clock. At elaboration the block scales all periods to whole ticks of a virtual fast clock. The tick is the greatest common divisor of the scaled periods. Each token has one bit per clock. A bit is set when that clock has a rising edge at the virtual instant the token stands for.

The block does not step one virtual tick at a time. It keeps a relative next-edge offset for each clock and moves straight to the nearest instant at which any clock edges, so it never sends a token with no bits set. Tokens leave through a valid/ready handshake, and the schedule moves forward only when a token is accepted. Alongside each token the block can report the virtual time that passed since the previous token.

For each clock the block also gives a constant spacing hint: the fewest host cycles between two edges of that same clock. The hint applies to one clock on its own. Two different clocks that both have a hint of 2 can still appear in back-to-back tokens.

Top module: `rational_clock_tokens`

## Requirements
- R1: Clock i has the ratio RATIO_NUM[i]/RATIO_DEN[i], a 16-bit field at bit 16*i of each parameter. Its period in virtual ticks is its ratio scaled by the product of all denominators, then divided by the greatest common divisor of all the scaled values.
- R2: Token bit i (bit 0 = clock 0) is 1 exactly when clock i has an edge at the token's virtual instant. Every clock edges at each whole multiple of its period.
- R3: The first token after reset has every bit set and a delta of 0.
- R4: No token is all zeros. Virtual instants at which no clock edges are skipped.
- R5: With EMIT_DELTA=1, tok_delta gives the virtual ticks between the previous token's instant and this token's instant.
- R6: While tok_valid is high and tok_ready is low, tok_bits and tok_delta hold their values. The schedule moves forward only on a cycle where both are high.
- R7: spacing_hint holds ceil(period_i / smallest period) in bits [i*HINT_W +: HINT_W].
- R8: tok_valid is low during reset. It rises on the first clock edge after reset is released and stays high from then on.
- R9: A single clock with period 1 gives a token of 1 on every accepted handshake.
- R10: With EMIT_DELTA=0, tok_delta is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_ready | input | 1 | Consumer accepts the current token |
| tok_valid | output | 1 | A token is presented |
| tok_bits | output | NUM_CLK | Edge bits, one per clock |
| tok_delta | output | OFF_W | Virtual ticks since the previous token |
| spacing_hint | output | NUM_CLK*HINT_W | Per-clock minimum host-cycle spacing |

## Verification
The bench goes after the ordering of near-coincident edges with periods 2, 3 and 4. In that set, clocks with the same spacing hint fire in consecutive tokens. A generator that steps one tick at a time would emit an all-zero token at tick 1. A design that gets the offset subtraction wrong drifts from the hand-listed six-token sequence. Ready is stalled at irregular points; a design that moves forward on valid alone skips tokens. A second instance with fractional ratios checks the GCD scaling, and a wrong reduction shows up as changed edge patterns. A third instance with one clock of period 1 and the delta output turned off checks the one-bit corner case and the masked delta.

// File: rtl/ctg_pkg.sv
package ctg_pkg;

  // Greatest common divisor, used at elaboration only.
  function automatic longint unsigned ctg_gcd(input longint unsigned a,
                                              input longint unsigned b);
    longint unsigned x;
    longint unsigned y;
    longint unsigned t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int unsigned ctg_ceil_div(input int unsigned n,
                                               input int unsigned d);
    return (n + d - 1) / d;
  endfunction

endpackage

// File: rtl/ctg_edge_lane.sv
// One clock's relative distance to its next edge.
module ctg_edge_lane #(
  parameter int unsigned W      = 3,
  parameter int unsigned PERIOD = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  input  logic [W-1:0] now_off,
  output logic [W-1:0] offset,
  output logic         fire
);

  localparam logic [W-1:0] PER_W = W'(PERIOD);

  logic [W-1:0] off_q;

  assign offset = off_q;
  assign fire   = (off_q == now_off);

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
    end else if (advance) begin
      if (fire) off_q <= off_q - now_off + PER_W;
      else      off_q <= off_q - now_off;
    end
  end

  // R2: a relative offset never exceeds the lane's own period
  a_r2_offset_bound: assert property (@(posedge clk) disable iff (rst)
    off_q <= PER_W);

  // R4: after any advance no lane sits at the instant just consumed
  a_r4_offset_nonzero: assert property (@(posedge clk) disable iff (rst)
    advance |=> off_q != '0);

endmodule

// File: rtl/ctg_min_select.sv
// Smallest of N offsets: the next virtual instant.
module ctg_min_select #(
  parameter int unsigned N = 3,
  parameter int unsigned W = 3
) (
  input  logic [N*W-1:0] vals,
  output logic [W-1:0]   min_val
);

  logic [W-1:0] chain [N];

  assign chain[0] = vals[W-1:0];

  generate
    for (genvar g = 1; g < N; g++) begin : g_stage
      logic [W-1:0] cand;
      assign cand     = vals[g*W +: W];
      assign chain[g] = (cand < chain[g-1]) ? cand : chain[g-1];
    end
  endgenerate

  assign min_val = chain[N-1];

endmodule

// File: rtl/ctg_token_out.sv
// Registered token with valid/ready.
module ctg_token_out #(
  parameter int unsigned N          = 3,
  parameter int unsigned W          = 3,
  parameter bit          EMIT_DELTA = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] fire_in,
  input  logic [W-1:0] delta_in,
  input  logic         ready,
  output logic         valid,
  output logic [N-1:0] bits,
  output logic [W-1:0] delta,
  output logic         load
);

  localparam logic [W-1:0] DMASK = EMIT_DELTA ? {W{1'b1}} : {W{1'b0}};

  logic         valid_q;
  logic [N-1:0] bits_q;
  logic [W-1:0] delta_q;

  assign load  = !valid_q || ready;
  assign valid = valid_q;
  assign bits  = bits_q;
  assign delta = delta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      bits_q  <= '0;
      delta_q <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      bits_q  <= fire_in;
      delta_q <= delta_in & DMASK;
    end
  end

  // R6: a stalled token stays put
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    valid_q && !ready |=> valid_q && $stable(bits_q) && $stable(delta_q));

  // R3: the first token out of reset has every clock edging
  a_r3_first_all_ones: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> (&bits_q) && delta_q == '0);

  // R8: once valid, always valid
  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q);

  generate
    if (EMIT_DELTA) begin : g_delta_chk
      // R5: every token after the first moves virtual time forward
      a_r5_delta_forward: assert property (@(posedge clk) disable iff (rst)
        valid_q && ready |=> delta_q != '0);
    end else begin : g_nodelta_chk
      // R10: masked delta
      a_r10_delta_zero: assert property (@(posedge clk) disable iff (rst)
        delta_q == '0);
    end
  endgenerate

endmodule

// File: rtl/rational_clock_tokens.sv
module rational_clock_tokens #(
  parameter int unsigned             NUM_CLK    = 3,
  parameter logic [NUM_CLK*16-1:0]   RATIO_NUM  = {16'd4, 16'd3, 16'd2},
  parameter logic [NUM_CLK*16-1:0]   RATIO_DEN  = {16'd1, 16'd1, 16'd1},
  parameter bit                      EMIT_DELTA = 1'b1,
  parameter int unsigned             HINT_W     = 8,
  localparam int unsigned            MAX_PER    = f_max_per(),
  localparam int unsigned            OFF_W      = (MAX_PER < 2) ? 1 : $clog2(MAX_PER + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tok_ready,
  output logic                        tok_valid,
  output logic [NUM_CLK-1:0]          tok_bits,
  output logic [OFF_W-1:0]            tok_delta,
  output logic [NUM_CLK*HINT_W-1:0]   spacing_hint
);

  import ctg_pkg::*;

  // ---- elaboration-time period scaling ----
  function automatic longint unsigned f_num(input int i);
    return longint'(RATIO_NUM[i*16 +: 16]);
  endfunction

  function automatic longint unsigned f_den(input int i);
    return longint'(RATIO_DEN[i*16 +: 16]);
  endfunction

  function automatic longint unsigned f_den_prod();
    longint unsigned p;
    p = 1;
    for (int i = 0; i < int'(NUM_CLK); i++) p = p * f_den(i);
    return p;
  endfunction

  function automatic longint unsigned f_scaled(input int i);
    return f_num(i) * f_den_prod() / f_den(i);
  endfunction

  function automatic longint unsigned f_gcd_all();
    longint unsigned g;
    g = f_scaled(0);
    for (int i = 1; i < int'(NUM_CLK); i++) g = ctg_gcd(g, f_scaled(i));
    return g;
  endfunction

  function automatic int unsigned f_period(input int i);
    return int'(f_scaled(i) / f_gcd_all());
  endfunction

  function automatic int unsigned f_max_per();
    int unsigned m;
    m = 0;
    for (int i = 0; i < int'(NUM_CLK); i++)
      if (f_period(i) > m) m = f_period(i);
    return m;
  endfunction

  function automatic int unsigned f_min_per();
    int unsigned m;
    m = f_period(0);
    for (int i = 1; i < int'(NUM_CLK); i++)
      if (f_period(i) < m) m = f_period(i);
    return m;
  endfunction

  localparam int unsigned MIN_PER = f_min_per();

  // ---- datapath ----
  logic [NUM_CLK*OFF_W-1:0] off_flat;
  logic [NUM_CLK-1:0]       fire_vec;
  logic [OFF_W-1:0]         now_off;
  logic                     load;

  generate
    for (genvar g = 0; g < NUM_CLK; g++) begin : g_lane
      localparam int unsigned LANE_PER = f_period(g);

      ctg_edge_lane #(
        .W      (OFF_W),
        .PERIOD (LANE_PER)
      ) u_lane (
        .clk     (clk),
        .rst     (rst),
        .advance (load),
        .now_off (now_off),
        .offset  (off_flat[g*OFF_W +: OFF_W]),
        .fire    (fire_vec[g])
      );

      assign spacing_hint[g*HINT_W +: HINT_W] =
        HINT_W'(ctg_ceil_div(LANE_PER, MIN_PER));
    end
  endgenerate

  ctg_min_select #(
    .N (NUM_CLK),
    .W (OFF_W)
  ) u_min (
    .vals    (off_flat),
    .min_val (now_off)
  );

  ctg_token_out #(
    .N          (NUM_CLK),
    .W          (OFF_W),
    .EMIT_DELTA (EMIT_DELTA)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .fire_in  (fire_vec),
    .delta_in (now_off),
    .ready    (tok_ready),
    .valid    (tok_valid),
    .bits     (tok_bits),
    .delta    (tok_delta),
    .load     (load)
  );

  // R4: nothing empty leaves the block
  a_r4_no_empty_token: assert property (@(posedge clk) disable iff (rst)
    tok_valid |-> tok_bits != '0);

  // R4: the candidate token fed to the output stage always has an edge
  a_r4_candidate_nonempty: assert property (@(posedge clk) disable iff (rst)
    fire_vec != '0);

  // R8: nothing presented while reset is being held
  a_r8_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !tok_valid);

endmodule

// File: tb/test_rational_clock_tokens.sv
module test_rational_clock_tokens;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [3:0] rdy;

  // DUT 0: periods 2,3,4
  logic        v0;
  logic [2:0]  b0;
  logic [2:0]  dl0;
  logic [23:0] h0;
  // DUT 1: ratios 1/2 and 3/4 -> periods 2,3
  logic        v1;
  logic [1:0]  b1;
  logic [1:0]  dl1;
  logic [15:0] h1;
  // DUT 2: single clock period 1, no delta
  logic        v2;
  logic [0:0]  b2;
  logic [0:0]  dl2;
  logic [7:0]  h2;

  rational_clock_tokens i_rational_clock_tokens (
    .clk(clk), .rst(rst), .tok_ready(rdy[0]),
    .tok_valid(v0), .tok_bits(b0), .tok_delta(dl0), .spacing_hint(h0));

  rational_clock_tokens #(
    .NUM_CLK(2), .RATIO_NUM({16'd3, 16'd1}), .RATIO_DEN({16'd4, 16'd2}),
    .EMIT_DELTA(1'b1), .HINT_W(8)
  ) i_rational_clock_tokens_rat (
    .clk(clk), .rst(rst), .tok_ready(rdy[1]),
    .tok_valid(v1), .tok_bits(b1), .tok_delta(dl1), .spacing_hint(h1));

  rational_clock_tokens #(
    .NUM_CLK(1), .RATIO_NUM(16'd5), .RATIO_DEN(16'd5),
    .EMIT_DELTA(1'b0), .HINT_W(8)
  ) i_rational_clock_tokens_one (
    .clk(clk), .rst(rst), .tok_ready(rdy[2]),
    .tok_valid(v2), .tok_bits(b2), .tok_delta(dl2), .spacing_hint(h2));

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  // behavioural model state, absolute virtual times
  int per  [3][4];
  int nxt  [3][4];
  int ncl  [3];
  int tprv [3];
  int exp_bits  [3];
  int exp_delta [3];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input int d);
    int tmin;
    int bv;
    tmin = 32'h7fffffff;
    for (int i = 0; i < ncl[d]; i++) if (nxt[d][i] < tmin) tmin = nxt[d][i];
    bv = 0;
    for (int i = 0; i < ncl[d]; i++) begin
      if (nxt[d][i] == tmin) begin
        bv = bv | (1 << i);
        nxt[d][i] = nxt[d][i] + per[d][i];
      end
    end
    exp_bits[d]  = bv;
    exp_delta[d] = (d == 2) ? 0 : tmin - tprv[d];
    tprv[d]      = tmin;
  endtask

  function automatic int obs_valid(input int d);
    return (d == 0) ? int'(v0) : (d == 1) ? int'(v1) : int'(v2);
  endfunction
  function automatic int obs_bits(input int d);
    return (d == 0) ? int'(b0) : (d == 1) ? int'(b1) : int'(b2);
  endfunction
  function automatic int obs_delta(input int d);
    return (d == 0) ? int'(dl0) : (d == 1) ? int'(dl1) : int'(dl2);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    int seq_idx;
    int seq_bits  [6];
    int seq_delta [6];
    int prev_bits [3];
    bit prev_stall [3];

    seq_bits  = '{1, 2, 4, 1, 3, 5};
    seq_delta = '{0, 2, 1, 1, 2, 2};
    // R2 sequence for periods 2,3,4: tokens at t=0,2,3,4,6,8; bit0=period-2 clock
    seq_bits  = '{7, 1, 2, 5, 3, 5};

    per[0][0] = 2; per[0][1] = 3; per[0][2] = 4; ncl[0] = 3;
    per[1][0] = 2; per[1][1] = 3; ncl[1] = 2;
    per[2][0] = 1; ncl[2] = 1;
    for (int d = 0; d < 3; d++) begin
      tprv[d] = 0;
      prev_stall[d] = 1'b0;
      prev_bits[d] = 0;
      for (int i = 0; i < 4; i++) nxt[d][i] = 0;
    end
    lfsr = 16'hACE1;
    seq_idx = 0;
    rdy = 4'b0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check(v0 == 1'b0 && v1 == 1'b0 && v2 == 1'b0, "R8 reset valid low",
          int'({v0, v1, v2}), 0);
    // R7: spacing hints
    check(h0 == {8'd2, 8'd2, 8'd1}, "R7 hints 2/3/4", int'(h0), int'({8'd2, 8'd2, 8'd1}));
    check(h1 == {8'd2, 8'd1}, "R7 hints rational", int'(h1), int'({8'd2, 8'd1}));
    check(h2 == 8'd1, "R7 hint single", int'(h2), 1);
    rst = 1'b0;
    for (int d = 0; d < 3; d++) model_step(d);
    rdy = 4'b0000;

    @(negedge clk);
    // R3: first token all ones, delta 0
    check(b0 == 3'b111 && dl0 == 3'd0, "R3 first token dut0", int'(b0), 7);
    check(b1 == 2'b11 && dl1 == 2'd0, "R3 first token dut1", int'(b1), 3);
    check(b2 == 1'b1, "R3 first token dut2", int'(b2), 1);

    for (int cyc = 0; cyc < 600; cyc++) begin
      if (cyc > 0) @(negedge clk);
      for (int d = 0; d < 3; d++) begin
        check(obs_valid(d) == 1, "R8 valid held high", obs_valid(d), 1);
        check(obs_bits(d) != 0, "R4 non-empty token", obs_bits(d), exp_bits[d]);
        check(obs_bits(d) == exp_bits[d], (d == 1) ? "R1 rational edge bits" : "R2 edge bits",
              obs_bits(d), exp_bits[d]);
        check(obs_delta(d) == exp_delta[d], (d == 2) ? "R10 delta masked" : "R5 delta",
              obs_delta(d), exp_delta[d]);
        if (prev_stall[d])
          check(obs_bits(d) == prev_bits[d], "R6 hold under stall", obs_bits(d), prev_bits[d]);
        if (d == 2) check(obs_bits(d) == 1, "R9 single clock token", obs_bits(d), 1);
      end
      // next ready pattern
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy[0] = (cyc < 12) ? 1'b1 : (lfsr[0] | lfsr[3]);
      rdy[1] = lfsr[5] | lfsr[9];
      rdy[2] = lfsr[2] | lfsr[7] | lfsr[11];
      if (cyc == 40) rdy[2:0] = 3'b000;
      for (int d = 0; d < 3; d++) begin
        prev_bits[d]  = obs_bits(d);
        prev_stall[d] = !rdy[d];
        if (rdy[d]) begin
          if (d == 0 && seq_idx < 6) begin
            check(int'(b0) == seq_bits[seq_idx], "R2 listed sequence bits", int'(b0), seq_bits[seq_idx]);
            check(int'(dl0) == seq_delta[seq_idx], "R5 listed sequence delta", int'(dl0), seq_delta[seq_idx]);
            seq_idx++;
          end
          model_step(d);
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule